// File: doc/BRIEF.md
# Serial-Controlled 16-Pin I/O Port Expander

This block lets a host configure and observe sixteen general-purpose pins over a four-wire serial link. The host sends 16-bit frames. Each frame carries a read flag, a register address, a padding bit and one data byte. The block holds a small byte-wide register file. Every pin function is split into a register pair: the low byte covers pins 0 to 7 and the next address covers pins 8 to 15.

The direction, drive-level and pull-up registers act on the pin outputs directly. The polarity, interrupt-enable, tri-state, interrupt-status and edge-select registers are only stored and read back. The pin-level registers return what the pins actually show. Each pin is brought out as three separate signals (drive value, drive enable and sampled input), so a surrounding model or pad ring can resolve the wire. The serial lines and the pin inputs are all resampled into the system clock domain. The serial clock must therefore be several times slower than the system clock.

Top module: `gpio_spi_expander`

## Requirements
- R1: After reset, every pin is an input (pin_oe all 0), pin_out and pin_pu are all 0, the direction pair (0x06, 0x07) reads 0xFF, and every other register reads 0x00.
- R2: A frame is 16 bits, sent MSB first in SPI mode 0 while spi_cs_n is low. Bit 15 is the read flag (1 = read). Bits 14:9 are the register address. Bit 8 is a pad bit whose value has no effect. Bits 7:0 are the data byte.
- R3: A write to any of the addresses 0x02 to 0x13 stores the byte, and a later read of that address returns it. This range covers drive, polarity, direction, pull-up, interrupt enable, tri-state, interrupt status, rising and falling edge select.
- R4: Pin n is driven (pin_oe[n] = 1) exactly when bit n%8 of direction register 0x06 + n/8 is 0. A 1 makes the pin an input.
- R5: pin_out[n] equals bit n%8 of drive register 0x02 + n/8.
- R6: pin_pu[n] equals bit n%8 of pull-up register 0x08 + n/8.
- R7: Reading 0x00 returns pin_in[7:0] and reading 0x01 returns pin_in[15:8], for input and output pins alike. The value seen is pin_in after two synchronizer stages and one capture register.
- R8: Writes to 0x00, 0x01, 0x14, 0x15 and to any address above 0x15 change no register and no pin output. Reads above 0x15 return 0x00. The interrupt-flag pair 0x14/0x15 always reads 0x00.
- R9: On a read, the addressed byte is captured when the eighth bit has been received and is shifted out MSB first on spi_miso during bits 7:0. A read changes no register, whatever data bits the host sends. spi_miso is 0 while the block is deselected.
- R10: A frame in which spi_cs_n rises before the sixteenth clock commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |
| pin_in | input | 16 | Observed pin levels |
| pin_out | output | 16 | Level to drive on each pin |
| pin_oe | output | 16 | Drive enable per pin, 1 = output |
| pin_pu | output | 16 | Pull-up enable per pin |

## Verification
The bench aims at the address corners. It writes to the read-only level and flag pairs and to addresses beyond 0x15. A decoder that only checked the low bits would alias those writes onto real registers and move pin outputs. It sets the pad bit on both reads and writes; a shifted field split would then hit the wrong register. Pins configured as outputs are read back through the level registers, which exposes a design that muxes the drive latch instead of the observed pin. Truncated frames and reads with all-ones data bits are sent as well, and either one corrupts a register in a design that commits on anything but a complete write frame.

// File: rtl/gxp_pkg.sv
package gxp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned FRAME_W   = 16;
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned NUM_PINS  = 16;
  localparam int unsigned NUM_BANKS = NUM_PINS / BYTE_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = 6'h15;
  localparam int unsigned NUM_REGS  = int'(LAST_ADDR) + 1;

  // Base address of each function pair; bank b lives at base + b.
  typedef enum logic [ADDR_W-1:0] {
    F_LEVEL    = 6'h00,
    F_DRIVE    = 6'h02,
    F_INVERT   = 6'h04,
    F_DIR      = 6'h06,
    F_PULL     = 6'h08,
    F_IRQ_EN   = 6'h0A,
    F_HIZ      = 6'h0C,
    F_IRQ_STAT = 6'h0E,
    F_RISE     = 6'h10,
    F_FALL     = 6'h12,
    F_FLAG     = 6'h14
  } func_base_e;

  function automatic logic [ADDR_W-1:0] pair_base(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], 1'b0};
  endfunction

  function automatic logic addr_valid(logic [ADDR_W-1:0] a);
    return a <= LAST_ADDR;
  endfunction

  function automatic logic addr_writable(logic [ADDR_W-1:0] a);
    return addr_valid(a) && (pair_base(a) != F_LEVEL) && (pair_base(a) != F_FLAG);
  endfunction

  function automatic logic [BYTE_W-1:0] reset_byte(logic [ADDR_W-1:0] a);
    return (pair_base(a) == F_DIR) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
  endfunction

  // Slot of a function byte for a given bank inside the flat store.
  function automatic int unsigned slot_lsb(func_base_e f, int unsigned bank);
    return (int'(f) + bank) * BYTE_W;
  endfunction
endpackage

// File: rtl/gxp_sync.sv
module gxp_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/gxp_spi_frame.sv
module gxp_spi_frame
  import gxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              miso
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam int unsigned SR_W  = FRAME_W - 1;

  logic             sclk_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [SR_W-1:0]  rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic             is_read;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             cmd_done;

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;

  // Command byte completes on the eighth rising edge: {rx_sr[6:0], mosi_s}.
  assign cmd_done  = sclk_rise && (bit_cnt == CNT_W'(CMD_W - 1));
  assign rd_addr   = rx_sr[ADDR_W-1:0];

  // Full frame on the sixteenth rising edge: {rx_sr[14:0], mosi_s}.
  assign wr_commit = sclk_rise && (bit_cnt == CNT_W'(FRAME_W - 1)) && !rx_sr[SR_W-1];
  assign wr_addr   = rx_sr[SR_W-2 -: ADDR_W];
  assign wr_data   = {rx_sr[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      is_read <= 1'b0;
    end else if (cs_n_s) begin
      bit_cnt <= '0;
      tx_sr   <= '0;
      is_read <= 1'b0;
    end else begin
      if (sclk_rise && (bit_cnt < CNT_W'(FRAME_W))) begin
        rx_sr   <= {rx_sr[SR_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (cmd_done) begin
        is_read <= rx_sr[CMD_W-2];
        tx_sr   <= rx_sr[CMD_W-2] ? rd_byte : '0;
      end else if (sclk_fall && (bit_cnt > CNT_W'(CMD_W))) begin
        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso = is_read & tx_sr[BYTE_W-1];
endmodule

// File: rtl/gxp_regs.sv
module gxp_regs
  import gxp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [NUM_PINS-1:0] level_in,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [NUM_PINS-1:0] dir_bits,
  output logic [NUM_PINS-1:0] drive_bits,
  output logic [NUM_PINS-1:0] pull_bits
);
  localparam int unsigned STORE_W = NUM_REGS * BYTE_W;

  logic [STORE_W-1:0]  store;
  logic [NUM_PINS-1:0] level_q;

  generate
    for (genvar a = 0; a < int'(NUM_REGS); a++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(a);
      if (addr_writable(MY_ADDR)) begin : g_rw
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                           q <= reset_byte(MY_ADDR);
          else if (wr_en && wr_addr == MY_ADDR) q <= wr_data;
        end
        assign store[a*BYTE_W +: BYTE_W] = q;
      end else begin : g_ro
        assign store[a*BYTE_W +: BYTE_W] = '0;
      end
    end

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
      assign dir_bits[b*BYTE_W +: BYTE_W]   = store[slot_lsb(F_DIR, b)   +: BYTE_W];
      assign drive_bits[b*BYTE_W +: BYTE_W] = store[slot_lsb(F_DRIVE, b) +: BYTE_W];
      assign pull_bits[b*BYTE_W +: BYTE_W]  = store[slot_lsb(F_PULL, b)  +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_in;
  end

  always_comb begin
    rd_data = '0;
    if (addr_valid(rd_addr)) begin
      if (pair_base(rd_addr) == F_LEVEL)
        rd_data = level_q[int'(rd_addr[0]) * BYTE_W +: BYTE_W];
      else
        rd_data = store[int'(rd_addr) * BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/gpio_spi_expander.sv
module gpio_spi_expander
  import gxp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sclk,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pu
);
  localparam int unsigned SPI_LINES = 3;

  logic [SPI_LINES-1:0] spi_s;
  logic [NUM_PINS-1:0]  pin_s;
  logic                 cs_idle;
  logic                 wr_commit;
  logic [ADDR_W-1:0]    wr_addr;
  logic [BYTE_W-1:0]    wr_data;
  logic [ADDR_W-1:0]    rd_addr;
  logic [BYTE_W-1:0]    rd_data;
  logic [NUM_PINS-1:0]  dir_bits;

  gxp_sync #(.WIDTH(SPI_LINES), .STAGES(SYNC_STAGES)) u_spi_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs_n, spi_sclk, spi_mosi}),
    .q     (spi_s)
  );

  gxp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  assign cs_idle = spi_s[2];

  gxp_spi_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (spi_s[1]),
    .cs_n_s    (cs_idle),
    .mosi_s    (spi_s[0]),
    .rd_byte   (rd_data),
    .rd_addr   (rd_addr),
    .wr_commit (wr_commit),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .miso      (spi_miso)
  );

  gxp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_commit),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .level_in   (pin_s),
    .rd_data    (rd_data),
    .dir_bits   (dir_bits),
    .drive_bits (pin_out),
    .pull_bits  (pin_pu)
  );

  assign pin_oe = ~dir_bits;
endmodule

// File: rtl/gxp_checker.sv
module gxp_checker
  import gxp_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                wr_commit,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                cs_idle,
  input logic                spi_miso,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_pu
);
  a_r4_dir_low_write_sets_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_addr == 6'h06) |=> (pin_oe[7:0] == ~$past(wr_data)));

  a_r5_drive_high_write_sets_out: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_addr == 6'h03) |=> (pin_out[15:8] == $past(wr_data)));

  a_r6_pull_low_write_sets_pu: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && wr_addr == 6'h08) |=> (pin_pu[7:0] == $past(wr_data)));

  a_r8_protected_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !addr_writable(wr_addr)) |=>
      ($stable(pin_oe) && $stable(pin_out) && $stable(pin_pu)));

  a_r3_outputs_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(pin_oe) && $stable(pin_out) && $stable(pin_pu)));

  a_r2_commit_is_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  a_r9_miso_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !spi_miso);
endmodule

bind gpio_spi_expander gxp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_commit (wr_commit),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .cs_idle   (cs_idle),
  .spi_miso  (spi_miso),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pin_pu    (pin_pu)
);

// File: tb/gpio_spi_expander_tb_top.sv
module gpio_spi_expander_tb_top;
  localparam int HALF = 6;  // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0;
  logic        spi_cs_n = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic [15:0] pin_pu;
  logic [15:0] ext_lvl = 16'h0000;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t       exp_q[$];
  logic [7:0] got_q[$];

  always #4 clk = ~clk;

  // Pad model: driven pins show their drive level, others the external level.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

  gpio_spi_expander dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (spi_sclk),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pin_pu   (pin_pu)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic spi_frame(input logic rd, input logic [5:0] addr, input logic pad,
                           input logic [7:0] data, input int nbits,
                           output logic [7:0] got);
    logic [15:0] f;
    f = {rd, addr, pad, data};
    got = '0;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 15; i >= 16 - nbits; i--) begin
      spi_mosi = f[i];
      repeat (HALF) @(negedge clk);
      if (i < 8) got[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] addr, input logic [7:0] data, input logic pad = 1'b0);
    logic [7:0] dummy;
    spi_frame(1'b0, addr, pad, data, 16, dummy);
  endtask

  task automatic rd_expect(input logic [5:0] addr, input logic [7:0] exp, input string tag,
                           input logic pad = 1'b0, input logic [7:0] fill = 8'h00);
    logic [7:0] got;
    exp_t e;
    e.val = exp;
    e.tag = tag;
    exp_q.push_back(e);
    spi_frame(1'b1, addr, pad, fill, 16, got);
    got_q.push_back(got);
  endtask

  // Monitor: pairs each captured read byte with its expectation.
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        exp_t e;
        logic [7:0] g;
        e = exp_q.pop_front();
        g = got_q.pop_front();
        check(e.tag, {24'd0, g}, {24'd0, e.val});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] junk;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", {16'd0, pin_oe}, 32'h0);
    check("R1 pin_out", {16'd0, pin_out}, 32'h0);
    check("R1 pin_pu", {16'd0, pin_pu}, 32'h0);
    rd_expect(6'h06, 8'hFF, "R1 dir low");
    rd_expect(6'h07, 8'hFF, "R1 dir high");
    rd_expect(6'h02, 8'h00, "R1 drive low");
    rd_expect(6'h0A, 8'h00, "R1 irq enable");

    // R5 drive latch, R3 readback
    wr(6'h02, 8'hA5);
    wr(6'h03, 8'h3C);
    check("R5 pin_out", {16'd0, pin_out}, 32'h3CA5);
    check("R4 still inputs", {16'd0, pin_oe}, 32'h0);
    rd_expect(6'h02, 8'hA5, "R3 drive low");
    rd_expect(6'h03, 8'h3C, "R3 drive high");

    // R4 direction
    wr(6'h06, 8'h0F);
    wr(6'h07, 8'hF0);
    check("R4 pin_oe", {16'd0, pin_oe}, 32'h0FF0);

    // R6 pull-ups
    wr(6'h09, 8'h81);
    check("R6 pin_pu", {16'd0, pin_pu}, 32'h8100);

    // R3 stored-only registers
    wr(6'h04, 8'h11); wr(6'h0A, 8'h22); wr(6'h0D, 8'h33);
    wr(6'h0E, 8'h44); wr(6'h11, 8'h55); wr(6'h13, 8'h66);
    rd_expect(6'h04, 8'h11, "R3 polarity");
    rd_expect(6'h0A, 8'h22, "R3 irq enable");
    rd_expect(6'h0D, 8'h33, "R3 tri-state high");
    rd_expect(6'h0E, 8'h44, "R3 irq status");
    rd_expect(6'h11, 8'h55, "R3 rise high");
    rd_expect(6'h13, 8'h66, "R3 fall high");

    // R7 pin levels: oe=0FF0, out=3CA5, ext=0000 -> 0CA0
    repeat (10) @(negedge clk);
    rd_expect(6'h00, 8'hA0, "R7 level low mixed");
    rd_expect(6'h01, 8'h0C, "R7 level high mixed");
    ext_lvl = 16'hFFFF;  // -> 0CA0 | F00F = FCAF
    repeat (10) @(negedge clk);
    rd_expect(6'h00, 8'hAF, "R7 level low ext high");
    rd_expect(6'h01, 8'hFC, "R7 level high ext high");

    // R8 protected and out-of-range addresses
    wr(6'h00, 8'h00);
    wr(6'h14, 8'h77);
    wr(6'h15, 8'h77);
    wr(6'h16, 8'h99);
    wr(6'h22, 8'h00);
    wr(6'h3F, 8'h00);
    rd_expect(6'h00, 8'hAF, "R8 level unwritable");
    rd_expect(6'h14, 8'h00, "R8 flag low");
    rd_expect(6'h15, 8'h00, "R8 flag high");
    rd_expect(6'h16, 8'h00, "R8 above range");
    rd_expect(6'h3F, 8'h00, "R8 top address");
    check("R8 pin_oe unchanged", {16'd0, pin_oe}, 32'h0FF0);
    check("R8 pin_out unchanged", {16'd0, pin_out}, 32'h3CA5);
    check("R8 pin_pu unchanged", {16'd0, pin_pu}, 32'h8100);

    // R2 pad bit ignored
    wr(6'h08, 8'h5A, 1'b1);
    check("R2 pad write pin_pu", {16'd0, pin_pu}, 32'h815A);
    rd_expect(6'h08, 8'h5A, "R2 pad read", 1'b1);

    // R10 truncated frame commits nothing
    spi_frame(1'b0, 6'h02, 1'b0, 8'h00, 12, junk);
    spi_frame(1'b0, 6'h07, 1'b0, 8'h00, 15, junk);
    check("R10 pin_out", {16'd0, pin_out}, 32'h3CA5);
    check("R10 pin_oe", {16'd0, pin_oe}, 32'h0FF0);

    // R9 read with all-ones data bits changes nothing; miso quiet after
    rd_expect(6'h03, 8'h3C, "R9 read ignores data", 1'b0, 8'hFF);
    rd_expect(6'h03, 8'h3C, "R9 value kept");
    check("R9 miso idle", {31'd0, spi_miso}, 32'h0);
    check("R9 pin_out after read", {16'd0, pin_out}, 32'h3CA5);

    // R1 reset mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 reset pin_oe", {16'd0, pin_oe}, 32'h0);
    check("R1 reset pin_out", {16'd0, pin_out}, 32'h0);
    rd_expect(6'h07, 8'hFF, "R1 reset dir high");

    repeat (20) @(negedge clk);
    check("R9 queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule